// File: doc/BRIEF.md
# Shared-Control Down-Counter Bank

The block holds eight independent 32-bit down-counters behind a plain word-wide register bus. Each counter has its own four-register group: live count, reload value and two compare values. All counters take their run, tick-source and interrupt settings from 4-bit fields packed into one shared control word. That word can be written whole or cleared bit by bit through a second address. Firmware that wants a free-running timestamp sets reload to all ones and enables the counter. Elapsed ticks are then the reload value minus the live count.

A counter steps either on every system clock or on a 1 MHz enable pulse. A divider derives that pulse from the system clock frequency given as a parameter. When a counter steps while at zero, it takes the reload value again. If the field asks for it, the same step raises a one-cycle overflow pulse. A step that lands the count on either compare value raises a one-cycle match pulse for that counter. Switching a counter off stops it and copies its reload value into the count. The fourth field bit is kept as plain storage.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads zero and every overflow and match output is low.
- R2: Timer n (from 1) has its count, reload, compare-A and compare-B registers at consecutive words. The bases are 0x00, 0x10 and 0x20 for timers 1 to 3, and 0x40 + 0x10*(n-4) for timers 4 to 8. Reload and compare registers read back what was written. The control word is at 0x30. Two further 32-bit storage words are at 0x34 and 0x38. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R3: Writes to a count register have no effect. Writes to unmapped or misaligned offsets change nothing, and reads from them return zero.
- R4: The control field of timer n occupies bits 4*(n-1)+3 down to 4*(n-1). Bit 0 of the field is run. With run set and bit 1 clear, the count drops by one on every clock. With run clear, the count holds.
- R5: With run and bit 1 both set, the count drops by exactly one per CLK_HZ/TICK_HZ clocks, i.e. at 1 MHz.
- R6: A step taken while the count is zero loads the reload value, so the count repeats with a period of reload+1 steps.
- R7: Field bit 2 set makes each reloading step raise `ovf_irq` for exactly one cycle, in the cycle the count shows the reload value. With bit 2 clear, no pulse appears.
- R8: Clearing the run bit stops the counter and loads its reload value into the count.
- R9: Writing offset 0x3C clears every control bit whose data bit is 1 and keeps the others. Reading 0x3C returns the control word.
- R10: A step that makes the count equal compare-A or compare-B raises `match_irq` for one cycle, in the cycle the count shows that value. Both compares equal to the value still give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| ovf_irq | output | N | Per-timer overflow pulse |
| match_irq | output | N | Per-timer compare pulse |

## Verification
The reloading step and a compare hit fall in the same clock when a compare register holds the reload value. The overflow pulse and the match pulse must then rise together. The bench sets compare-A of timer 8 to its reload value and compare-B to a mid-period value. Over a window of whole periods, it counts overflow pulses, match pulses and cycles where both are high. It then moves both compares onto one value and expects one match per period with no overlap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int FLD_W    = 4;
  localparam int B_RUN    = 0;
  localparam int B_FAST   = 1;
  localparam int B_IE     = 2;
  localparam int B_WAVE   = 3;

  localparam int LOW_CNT  = 3;
  localparam int OFF_CTL  = 'h30;
  localparam int OFF_AUX0 = 'h34;
  localparam int OFF_AUX1 = 'h38;
  localparam int OFF_CLR  = 'h3C;
  localparam int HI_BASE  = 'h40;
  localparam int GRP_SZ   = 'h10;

  typedef struct packed {
    logic wave;
    logic ie;
    logic fast;
    logic run;
  } fld_t;

  typedef enum logic [1:0] {
    SL_COUNT  = 2'd0,
    SL_RELOAD = 2'd1,
    SL_CMPA   = 2'd2,
    SL_CMPB   = 2'd3
  } slot_e;
endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      logic          tick_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          tick_q <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
          cnt    <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          tick_q <= 1'b0;
        end
      end
      assign tick = tick_q;
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_fast,
  input  logic         run,
  input  logic         fast,
  input  logic         ie,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         ovf_pulse,
  output logic         hit_pulse
);
  logic         run_q;
  logic         step;
  logic         at_zero;
  logic [W-1:0] nxt;

  assign step    = run && (fast ? tick_fast : 1'b1);
  assign at_zero = (count == '0);
  assign nxt     = at_zero ? reload : count - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      count     <= '0;
      ovf_pulse <= 1'b0;
      hit_pulse <= 1'b0;
    end else begin
      run_q     <= run;
      ovf_pulse <= step && at_zero && ie;
      hit_pulse <= step && ((nxt == cmp_a) || (nxt == cmp_b));
      if (!run && run_q)
        count <= reload;
      else if (step)
        count <= nxt;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [AW-1:0]           addr,
  input  logic [W-1:0]            wdata,
  output logic [W-1:0]            rdata,
  input  logic [N-1:0][W-1:0]     counts,
  output logic [N*FLD_W-1:0]      ctl,
  output logic [N-1:0][W-1:0]     reload,
  output logic [N-1:0][W-1:0]     cmp_a,
  output logic [N-1:0][W-1:0]     cmp_b
);
  localparam int CW     = N * FLD_W;
  localparam int IW     = (N > 1) ? $clog2(N) : 1;
  localparam int HI_END = HI_BASE + (N - LOW_CNT) * GRP_SZ;

  logic [W-1:0]  aux0, aux1;
  logic          hit_tmr, hit_ctl, hit_clr, hit_aux0, hit_aux1;
  logic [IW-1:0] idx;
  slot_e         slot;
  logic [AW-1:0] rel;
  logic [W-1:0]  rd_val;
  int            a_int;

  always_comb begin
    a_int    = int'(addr);
    rel      = addr - AW'(HI_BASE);
    slot     = slot_e'(addr[3:2]);
    hit_tmr  = 1'b0;
    hit_ctl  = 1'b0;
    hit_clr  = 1'b0;
    hit_aux0 = 1'b0;
    hit_aux1 = 1'b0;
    idx      = '0;
    if (addr[1:0] == 2'b00) begin
      if (a_int < LOW_CNT * GRP_SZ) begin
        hit_tmr = 1'b1;
        idx     = IW'(addr[AW-1:4]);
      end else if (a_int == OFF_CTL) begin
        hit_ctl = 1'b1;
      end else if (a_int == OFF_AUX0) begin
        hit_aux0 = 1'b1;
      end else if (a_int == OFF_AUX1) begin
        hit_aux1 = 1'b1;
      end else if (a_int == OFF_CLR) begin
        hit_clr = 1'b1;
      end else if (a_int >= HI_BASE && a_int < HI_END) begin
        hit_tmr = 1'b1;
        idx     = IW'(rel[AW-1:4]) + IW'(LOW_CNT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      aux0   <= '0;
      aux1   <= '0;
      reload <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
    end else if (wr) begin
      if (hit_ctl)  ctl  <= wdata[CW-1:0];
      if (hit_clr)  ctl  <= ctl & ~wdata[CW-1:0];
      if (hit_aux0) aux0 <= wdata;
      if (hit_aux1) aux1 <= wdata;
      if (hit_tmr) begin
        case (slot)
          SL_RELOAD: reload[idx] <= wdata;
          SL_CMPA:   cmp_a[idx]  <= wdata;
          SL_CMPB:   cmp_b[idx]  <= wdata;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctl || hit_clr) rd_val = W'(ctl);
    else if (hit_aux0)      rd_val = aux0;
    else if (hit_aux1)      rd_val = aux1;
    else if (hit_tmr) begin
      case (slot)
        SL_COUNT:  rd_val = counts[idx];
        SL_RELOAD: rd_val = reload[idx];
        SL_CMPA:   rd_val = cmp_a[idx];
        default:   rd_val = cmp_b[idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tmr_pkg::*;
#(
  parameter int N       = 8,
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [N-1:0]  ovf_irq,
  output logic [N-1:0]  match_irq
);
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int CW  = N * FLD_W;

  logic [CW-1:0]         ctl_w;
  logic [N-1:0][W-1:0]   count_v, reload_v, cmpa_v, cmpb_v;
  logic                  tick_fast;

  tmr_regs #(.N(N), .W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .counts(count_v), .ctl(ctl_w),
    .reload(reload_v), .cmp_a(cmpa_v), .cmp_b(cmpb_v)
  );

  tmr_tick_div #(.DIV(DIV)) u_div (.clk(clk), .rst(rst), .tick(tick_fast));

  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      fld_t f;
      assign f = fld_t'(ctl_w[i*FLD_W +: FLD_W]);
      tmr_channel #(.W(W)) u_ch (
        .clk(clk), .rst(rst), .tick_fast(tick_fast),
        .run(f.run), .fast(f.fast), .ie(f.ie),
        .reload(reload_v[i]), .cmp_a(cmpa_v[i]), .cmp_b(cmpb_v[i]),
        .count(count_v[i]), .ovf_pulse(ovf_irq[i]), .hit_pulse(match_irq[i])
      );
    end
  endgenerate
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import tmr_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [W-1:0]          bus_wdata,
  input logic [N*FLD_W-1:0]    ctl_w,
  input logic [N-1:0][W-1:0]   count_v,
  input logic [N-1:0][W-1:0]   reload_v,
  input logic [N-1:0]          ovf_irq,
  input logic [N-1:0]          match_irq
);
  // R9: clear alias
  a_r9_alias_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == OFF_CLR)
      |=> ctl_w == ($past(ctl_w) & ~$past(bus_wdata[N*FLD_W-1:0])));

  generate
    for (genvar i = 0; i < N; i++) begin : g_c
      // R4: counts down by one on each system clock
      a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (ctl_w[i*FLD_W+B_RUN] && !ctl_w[i*FLD_W+B_FAST] && count_v[i] != '0)
          |=> count_v[i] == $past(count_v[i]) - 1'b1);
      // R4: holds while stopped
      a_r4_hold_off: assert property (@(posedge clk) disable iff (rst)
        (!ctl_w[i*FLD_W+B_RUN] && !$past(ctl_w[i*FLD_W+B_RUN]))
          |=> $stable(count_v[i]));
      // R6: wrap from zero loads reload
      a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (ctl_w[i*FLD_W+B_RUN] && !ctl_w[i*FLD_W+B_FAST] && count_v[i] == '0)
          |=> count_v[i] == $past(reload_v[i]));
      // R8: stop loads reload
      a_r8_stop_load: assert property (@(posedge clk) disable iff (rst)
        (!ctl_w[i*FLD_W+B_RUN] && $past(ctl_w[i*FLD_W+B_RUN]))
          |=> count_v[i] == $past(reload_v[i]));
      // R7: overflow only with run and interrupt enable
      a_r7_ovf_gated: assert property (@(posedge clk) disable iff (rst)
        ovf_irq[i] |-> ($past(ctl_w[i*FLD_W+B_IE]) && $past(ctl_w[i*FLD_W+B_RUN])));
      // R10: compare pulse only from a running counter
      a_r10_match_run: assert property (@(posedge clk) disable iff (rst)
        match_irq[i] |-> $past(ctl_w[i*FLD_W+B_RUN]));
    end
  endgenerate
endmodule

bind timer_bank timer_bank_chk #(.N(N), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctl_w(ctl_w), .count_v(count_v),
  .reload_v(reload_v), .ovf_irq(ovf_irq), .match_irq(match_irq)
);

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
  localparam int N = 8, W = 32, AW = 8, DIV = 50;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0, bus_rdata;
  logic [N-1:0]  ovf_irq, match_irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  timer_bank i_timer_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_irq(ovf_irq), .match_irq(match_irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input int a, input logic [W-1:0] d);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    bus_rd = 1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd('h30, v); chk("R1 ctl", v, 0);
    rd('h04, v); chk("R1 reload t1", v, 0);
    rd('h84, v); chk("R1 reload t8", v, 0);
    rd('h40, v); chk("R1 count t4", v, 0);
    chk("R1 irqs", {16'h0, ovf_irq, match_irq}, 0);
  endtask

  task automatic t_regmap();
    logic [W-1:0] v;
    wr('h04, 32'h1111_0001); wr('h28, 32'h3333_000A); wr('h4C, 32'h4444_000B);
    wr('h84, 32'h8888_0004); wr('h34, 32'hDEAD_BEEF); wr('h38, 32'h0BAD_F00D);
    rd('h04, v); chk("R2 reload t1", v, 32'h1111_0001);
    rd('h28, v); chk("R2 cmpA t3", v, 32'h3333_000A);
    rd('h4C, v); chk("R2 cmpB t4", v, 32'h4444_000B);
    rd('h84, v); chk("R2 reload t8", v, 32'h8888_0004);
    rd('h34, v); chk("R2 aux0", v, 32'hDEAD_BEEF);
    rd('h38, v); chk("R2 aux1", v, 32'h0BAD_F00D);
  endtask

  task automatic t_readonly_unmapped();
    logic [W-1:0] v;
    wr('h00, 32'h1234_5678);
    rd('h00, v); chk("R3 count read-only", v, 0);
    wr('h90, 32'hFFFF_FFFF); wr('hF4, 32'hFFFF_FFFF); wr('h86, 32'h5555_5555);
    rd('h90, v); chk("R3 unmapped read", v, 0);
    rd('h85, v); chk("R3 misaligned read", v, 0);
    rd('h84, v); chk("R3 reload t8 untouched", v, 32'h8888_0004);
    rd('h30, v); chk("R3 ctl untouched", v, 0);
  endtask

  task automatic t_sysclk();
    logic [W-1:0] a, b, c;
    wr('h14, 32'd1000);
    wr('h30, 32'h0000_0010);          // timer 2 run: bits 7..4
    idle(3);
    rd('h10, a);
    idle(20);
    rd('h10, b);                       // 21 clocks after first read
    chk("R4 sysclk step", a - b, 21);
    rd('h00, c); chk("R4 field position t1 idle", c, 0);
    // R8/R9: stop through the clear alias
    wr('h3C, 32'h0000_0010);
    idle(2);
    rd('h10, a); chk("R8 stop loads reload", a, 1000);
    idle(10);
    rd('h10, b); chk("R4 hold while stopped", b, 1000);
  endtask

  task automatic t_alias();
    logic [W-1:0] v;
    wr('h30, 32'h0000_00A5);
    wr('h3C, 32'h0000_0021);
    rd('h30, v); chk("R9 clear ones only", v, 32'h84);
    rd('h3C, v); chk("R9 alias reads ctl", v, 32'h84);
    wr('h3C, 32'h0);
    rd('h30, v); chk("R9 zero keeps", v, 32'h84);
    wr('h30, 32'h0);
  endtask

  task automatic t_fast();
    logic [W-1:0] a, b;
    wr('h44, 32'h0000_1000);
    wr('h30, 32'h0000_3000);          // timer 4 run+fast
    idle(2*DIV);
    rd('h40, a);
    idle(5*DIV - 1);
    rd('h40, b);
    chk("R5 fast tick rate", a - b, 5);
    wr('h30, 32'h0);
  endtask

  task automatic t_overflow();
    int p; logic prev; logic dbl;
    wr('h24, 32'd3); wr('h28, 32'hFFFF); wr('h2C, 32'hFFFF);
    wr('h30, 32'h0000_0500);          // timer 3 run+ie
    idle(8);
    p = 0; prev = 0; dbl = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ovf_irq[2]) p++;
      if (ovf_irq[2] && prev) dbl = 1;
      prev = ovf_irq[2];
    end
    chk("R6 period reload+1", p, 10);
    chk("R7 single-cycle pulse", dbl, 0);
    wr('h30, 32'h0000_0100);          // drop ie, keep running
    idle(2);
    p = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ovf_irq[2]) p++;
    end
    chk("R7 no pulse without ie", p, 0);
    wr('h30, 32'h0);
  endtask

  task automatic t_match();
    int no, nm, nb;
    wr('h84, 32'd4); wr('h88, 32'd4); wr('h8C, 32'd2);
    wr('h30, 32'h5000_0000);          // timer 8 run+ie
    idle(12);
    no = 0; nm = 0; nb = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (ovf_irq[7]) no++;
      if (match_irq[7]) nm++;
      if (ovf_irq[7] && match_irq[7]) nb++;
    end
    chk("R7 overflow count", no, 10);
    chk("R10 match count", nm, 20);
    chk("R10 match with overflow", nb, 10);
    wr('h88, 32'd2);
    idle(6);
    nm = 0; nb = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (match_irq[7]) nm++;
      if (ovf_irq[7] && match_irq[7]) nb++;
    end
    chk("R10 equal compares one pulse", nm, 10);
    chk("R10 no overlap", nb, 0);
    wr('h30, 32'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_readonly_unmapped();
    t_sysclk();
    t_alias();
    t_fast();
    t_overflow();
    t_match();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule